// File: doc/BRIEF.md
# Configurable Modular Butterfly Unit

This block is the arithmetic element of a pipelined number-theoretic-transform datapath over the prime field of q = 8380417. It accepts two 23-bit coefficients and a twiddle factor each cycle, together with a 3-bit operation code. It returns two 23-bit results after a fixed pipeline delay. The same hardware serves the forward transform with a decimation-in-time butterfly and the inverse transform with a decimation-in-frequency butterfly. It also serves plain coefficient-wise multiply, add and subtract passes, so the surrounding transform engine needs no separate arithmetic for those jobs.

Only one modular multiplier, one modular adder and one modular subtractor exist. Multiplexers place the adder/subtractor pair either after the multiplier, for the forward butterfly and the pointwise modes, or before it, for the inverse butterfly. The inverse butterfly halves its sum modulo q with a shift and a conditional add. The usual final scaling by the inverse of the transform length therefore disappears. The inverse twiddles are expected already scaled by any remaining constant. Because the two butterfly forms use the adder at different pipeline positions, the operation code is a stream setting. It may change only while the pipeline holds no valid item.

Top module: `ntt_bf_unit`

## Requirements
- R1: With all inputs in [0, q), q = 8380417, both a_o and b_o are in [0, q) whenever vld_o is high.
- R2: Operation code 0 (forward butterfly): a_o = (a + b·w) mod q and b_o = (a − b·w) mod q.
- R3: Operation code 1 (inverse butterfly): a_o = (a + b)·2^-1 mod q and b_o = (a − b)·w mod q. The halving uses (x >> 1) + x[0]·4190209 and no multiplier.
- R4: Operation code 2 (pointwise multiply): b_o = b·w mod q. Input a does not affect b_o.
- R5: Operation code 3 (pointwise add): a_o = (a + b) mod q.
- R6: Operation code 4 (pointwise subtract): b_o = (a − b) mod q.
- R7: Results and vld_o appear on the fifth rising edge after the edge that samples vld_i high, identically in every mode. One item is accepted per cycle, in order. vld_o is never high without a matching input.
- R8: While rst_ni is low, vld_o, a_o and b_o are all zero, and any vld_i is ignored.
- R9: The operation code may change only when no valid item has been accepted in the previous five cycles. Codes 5 to 7 behave as code 2.
- R10: Wrap-around at the field edges is exact: inputs 0, 1, q−1 and q−2 in any combination give the R2 to R6 results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input item valid |
| op_i | input | 3 | Operation code, see R2 to R6 and R9 |
| a_i | input | 23 | First coefficient, in [0, q) |
| b_i | input | 23 | Second coefficient, in [0, q) |
| w_i | input | 23 | Twiddle or multiplier operand, in [0, q) |
| vld_o | output | 1 | Output item valid |
| a_o | output | 23 | First result |
| b_o | output | 23 | Second result |

## Verification
A corrupted stage register or a wrong multiplexer select shows up on the ports exactly five edges after the affected item was accepted. The error appears on one result port and only in the modes that route through that path. A misrouted inverse path, for example, leaves the forward results correct. Each mode is therefore run on its own with random operands and on the full grid of field-edge values, and every output item is compared with a remainder-operator model and with its expected arrival cycle. A faulty reduction constant or correction step shows as an out-of-range or off-by-q value on the first product that crosses the boundary. Valid-tag errors show as missing, extra or shifted output items.

// File: rtl/ntt_bf_pkg.sv
package ntt_bf_pkg;
  localparam int unsigned CW      = 23;
  localparam int unsigned MOD_Q   = 8380417;
  localparam int unsigned MUL_LAT = 3;
  localparam int unsigned OPW     = 3;
  localparam logic [CW-1:0] HALF_Q = CW'((MOD_Q + 1) / 2);

  localparam logic [OPW-1:0] OP_CT  = 3'd0;
  localparam logic [OPW-1:0] OP_GS  = 3'd1;
  localparam logic [OPW-1:0] OP_MUL = 3'd2;
  localparam logic [OPW-1:0] OP_ADD = 3'd3;
  localparam logic [OPW-1:0] OP_SUB = 3'd4;

  typedef struct packed {
    logic           vld;
    logic [OPW-1:0] op;
    logic [CW-1:0]  aux;
    logic [CW-1:0]  b;
  } bf_tag_t;

  // halving mod q without a multiplier
  function automatic logic [CW-1:0] mod_half(input logic [CW-1:0] x);
    return (x >> 1) + (x[0] ? HALF_Q : '0);
  endfunction
endpackage

// File: rtl/ntt_mod_add.sv
module ntt_mod_add #(
  parameter int unsigned W = 23,
  parameter int unsigned Q = 8380417
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  localparam logic [W:0] QX = (W+1)'(Q);
  logic [W:0] sum;
  logic [W:0] red;
  always_comb begin
    sum = {1'b0, x_i} + {1'b0, y_i};
    red = (sum >= QX) ? sum - QX : sum;
    s_o = red[W-1:0];
  end
endmodule

// File: rtl/ntt_mod_sub.sv
module ntt_mod_sub #(
  parameter int unsigned W = 23,
  parameter int unsigned Q = 8380417
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] d_o
);
  localparam logic [W:0] QX = (W+1)'(Q);
  logic [W:0] dif;
  logic [W:0] fix;
  always_comb begin
    dif = {1'b0, x_i} - {1'b0, y_i};
    fix = (x_i >= y_i) ? dif : dif + QX;
    d_o = fix[W-1:0];
  end
endmodule

// File: rtl/ntt_mod_mul.sv
// Three-stage modular multiplier: product, Barrett quotient estimate, correction.
module ntt_mod_mul #(
  parameter int unsigned W = 23,
  parameter int unsigned Q = 8380417
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] r_o
);
  localparam int unsigned K   = 2 * W;
  localparam int unsigned PW  = 2 * W;
  localparam int unsigned BW  = 3 * W + 1;
  localparam longint unsigned MU_L = (64'd1 << K) / longint'(Q);
  localparam logic [W:0]    MU  = MU_L[W:0];
  localparam logic [PW-1:0] QP  = PW'(Q);
  localparam logic [W+1:0]  Q1  = (W+2)'(Q);
  localparam logic [W+1:0]  Q2  = (W+2)'(2 * Q);

  logic [PW-1:0] p1_q, p2_q;
  logic [W:0]    qh_q;
  logic [BW-1:0] bprod;
  logic [PW-1:0] qq;
  logic [PW-1:0] rem_full;
  logic [W+1:0]  rem;
  logic [W+1:0]  rem_c;

  always_comb begin
    bprod    = {{(W+1){1'b0}}, p1_q} * {{PW{1'b0}}, MU};
    qq       = {{(W-1){1'b0}}, qh_q} * QP;
    rem_full = p2_q - qq;
    rem      = rem_full[W+1:0];
    if (rem >= Q2)      rem_c = rem - Q2;
    else if (rem >= Q1) rem_c = rem - Q1;
    else                rem_c = rem;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0;
      p2_q <= '0;
      qh_q <= '0;
      r_o  <= '0;
    end else begin
      p1_q <= {{W{1'b0}}, x_i} * {{W{1'b0}}, y_i};
      p2_q <= p1_q;
      qh_q <= bprod[K +: W+1];
      r_o  <= rem_c[W-1:0];
    end
  end
endmodule

// File: rtl/ntt_bf_unit.sv
module ntt_bf_unit
  import ntt_bf_pkg::*;
#(
  parameter int unsigned W = CW,
  parameter int unsigned Q = MOD_Q
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   w_i,
  output logic           vld_o,
  output logic [W-1:0]   a_o,
  output logic [W-1:0]   b_o
);
  localparam int unsigned DL = MUL_LAT;

  // stage 0: input capture
  logic           s0_vld;
  logic [OPW-1:0] s0_op;
  logic [W-1:0]   s0_a, s0_b, s0_w;
  // stage 1: multiplier operands and side data
  logic           s1_vld;
  logic [OPW-1:0] s1_op;
  logic [W-1:0]   s1_aux, s1_b, s1_mx, s1_my;

  bf_tag_t dl_q [DL];
  bf_tag_t tl;

  logic [W-1:0] mul_r;
  logic [W-1:0] add_x, add_y, add_r;
  logic [W-1:0] sub_r;
  logic         front_sel;
  logic         back_pw;

  always_comb begin
    tl        = dl_q[DL-1];
    front_sel = s0_vld && (s0_op == OP_GS);
    back_pw   = (tl.op == OP_ADD) || (tl.op == OP_SUB);
    // shared adder/subtractor: before the multiplier for the inverse form, after it otherwise
    add_x     = front_sel ? s0_a : tl.aux;
    add_y     = front_sel ? s0_b : (back_pw ? tl.b : mul_r);
  end

  ntt_mod_add #(.W(W), .Q(Q)) u_add (.x_i(add_x), .y_i(add_y), .s_o(add_r));
  ntt_mod_sub #(.W(W), .Q(Q)) u_sub (.x_i(add_x), .y_i(add_y), .d_o(sub_r));
  ntt_mod_mul #(.W(W), .Q(Q)) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .x_i   (s1_mx),
    .y_i   (s1_my),
    .r_o   (mul_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_vld <= 1'b0;
      s0_op  <= '0;
      s0_a   <= '0;
      s0_b   <= '0;
      s0_w   <= '0;
    end else begin
      s0_vld <= vld_i;
      s0_op  <= op_i;
      s0_a   <= a_i;
      s0_b   <= b_i;
      s0_w   <= w_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s1_op  <= '0;
      s1_aux <= '0;
      s1_b   <= '0;
      s1_mx  <= '0;
      s1_my  <= '0;
    end else begin
      s1_vld <= s0_vld;
      s1_op  <= s0_op;
      s1_aux <= front_sel ? mod_half(add_r) : s0_a;
      s1_b   <= s0_b;
      s1_mx  <= front_sel ? sub_r : s0_b;
      s1_my  <= s0_w;
    end
  end

  // side data delay matched to the multiplier
  for (genvar i = 0; i < DL; i++) begin : g_dl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dl_q[i] <= '0;
      end else if (i == 0) begin
        dl_q[i] <= '{vld: s1_vld, op: s1_op, aux: s1_aux, b: s1_b};
      end else begin
        dl_q[i] <= dl_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      a_o   <= '0;
      b_o   <= '0;
    end else begin
      vld_o <= tl.vld;
      a_o   <= (tl.op == OP_GS) ? tl.aux : add_r;
      b_o   <= ((tl.op == OP_CT) || (tl.op == OP_SUB)) ? sub_r : mul_r;
    end
  end
endmodule

// File: rtl/ntt_bf_unit_chk.sv
module ntt_bf_unit_chk
  import ntt_bf_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           vld_i,
  input logic [OPW-1:0] op_i,
  input logic [CW-1:0]  a_i,
  input logic [CW-1:0]  b_i,
  input logic [CW-1:0]  w_i,
  input logic           vld_o,
  input logic [CW-1:0]  a_o,
  input logic [CW-1:0]  b_o
);
  localparam int unsigned LAT = 6;

  logic [2:0]     warm;
  logic [4:0]     vsh;
  logic [OPW-1:0] last_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm    <= '0;
      vsh     <= '0;
      last_op <= '0;
    end else begin
      if (warm < 3'(LAT)) warm <= warm + 3'd1;
      vsh <= {vsh[3:0], vld_i};
      if (vld_i) last_op <= op_i;
    end
  end

  function automatic logic [CW-1:0] ref_add(input logic [CW-1:0] x, input logic [CW-1:0] y);
    int unsigned s;
    s = int'(x) + int'(y);
    return CW'(s % MOD_Q);
  endfunction

  function automatic logic [CW-1:0] ref_sub(input logic [CW-1:0] x, input logic [CW-1:0] y);
    int unsigned s;
    s = int'(x) + MOD_Q - int'(y);
    return CW'(s % MOD_Q);
  endfunction

  // R8
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_out_chk: assert (!vld_o && a_o == '0 && b_o == '0);
    end
  end

  // R1
  out_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (a_o < CW'(MOD_Q)) && (b_o < CW'(MOD_Q)));

  // R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm >= 3'(LAT)) |-> (vld_o == $past(vld_i, 6)));

  // R5
  pw_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((warm >= 3'(LAT)) && $past(vld_i, 6) && ($past(op_i, 6) == OP_ADD))
    |-> (a_o == ref_add($past(a_i, 6), $past(b_i, 6))));

  // R6
  pw_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((warm >= 3'(LAT)) && $past(vld_i, 6) && ($past(op_i, 6) == OP_SUB))
    |-> (b_o == ref_sub($past(a_i, 6), $past(b_i, 6))));

  // R9
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (|vsh)) |-> (op_i == last_op));

  // R7
  no_phantom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((warm >= 3'(LAT)) && !$past(vld_i, 6)) |-> !vld_o);

  logic unused_w;
  assign unused_w = ^w_i;
endmodule

bind ntt_bf_unit ntt_bf_unit_chk u_chk (.*);

// File: tb/ntt_bf_unit_tb.sv
`timescale 1ns/1ps
module ntt_bf_unit_tb;
  import ntt_bf_pkg::*;

  localparam longint QL = 64'd8380417;
  localparam longint HL = 64'd4190209;
  localparam int LAT_NEG = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          vld_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [22:0]   a_i = '0, b_i = '0, w_i = '0;
  logic          vld_o;
  logic [22:0]   a_o, b_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int ta [64];
  int tb_v [64];
  int tw [64];

  always #2 clk = ~clk;

  ntt_bf_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .w_i(w_i),
    .vld_o(vld_o), .a_o(a_o), .b_o(b_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      3: return "R5";
      4: return "R6";
      2: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic ref_model(input int op, input longint a, input longint b, input longint w,
                           output longint ea, output longint eb, output bit ca, output bit cb);
    longint p;
    ca = 1'b1; cb = 1'b1; ea = 0; eb = 0;
    case (op)
      0: begin p = (b * w) % QL; ea = (a + p) % QL; eb = (a - p + QL) % QL; end
      1: begin ea = (((a + b) % QL) * HL) % QL; eb = (((a - b + QL) % QL) * w) % QL; end
      3: begin ea = (a + b) % QL; cb = 1'b0; end
      4: begin eb = (a - b + QL) % QL; ca = 1'b0; end
      default: begin eb = (b * w) % QL; ca = 1'b0; end
    endcase
  endtask

  // drives n items from the tables with gap idle cycles between, checks each result and its arrival
  task automatic run_batch(input int op, input int n, input int gap, input string tag);
    int sent = 0, got = 0, idle = 0, cyc = 0;
    int in_cyc [64];
    longint ea, eb;
    bit ca, cb;
    while (got < n && cyc < n * (gap + 1) + 20) begin
      @(negedge clk);
      cyc++;
      if (vld_o) begin
        ref_model(op, ta[got], tb_v[got], tw[got], ea, eb, ca, cb);
        if (ca) check(longint'(a_o) == ea, {req_of(op), " ", tag, " a_o"}, a_o, ea);
        if (cb) check(longint'(b_o) == eb, {req_of(op), " ", tag, " b_o"}, b_o, eb);
        check((a_o < 23'd8380417) && (b_o < 23'd8380417), {"R1 ", tag}, ca ? a_o : b_o, QL - 1);
        check(cyc - in_cyc[got] == LAT_NEG, {"R7 latency ", tag}, cyc - in_cyc[got], LAT_NEG);
        got++;
      end
      if (sent < n && idle == 0) begin
        vld_i = 1'b1; op_i = 3'(op);
        a_i = 23'(ta[sent]); b_i = 23'(tb_v[sent]); w_i = 23'(tw[sent]);
        in_cyc[sent] = cyc;
        sent++;
        idle = gap;
      end else begin
        vld_i = 1'b0;
        a_i = 23'(QL - 1); b_i = 23'(QL - 1); w_i = 23'(QL - 1);
        if (idle > 0) idle--;
      end
    end
    vld_i = 1'b0;
    check(got == n, {"R7 count ", tag}, got, n);
    repeat (LAT_NEG + 2) begin
      @(negedge clk);
      check(!vld_o, {"R7 no extra ", tag}, vld_o, 0);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < 64; i++) begin
      ta[i] = int'($urandom % 32'd8380417);
      tb_v[i] = int'($urandom % 32'd8380417);
      tw[i] = int'($urandom % 32'd8380417);
    end
  endtask

  task automatic fill_edges();
    int vals [4];
    vals[0] = 0; vals[1] = 1; vals[2] = int'(QL - 1); vals[3] = int'(QL - 2);
    for (int i = 0; i < 64; i++) begin
      ta[i] = vals[i % 4];
      tb_v[i] = vals[(i / 4) % 4];
      tw[i] = vals[i / 16];
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    vld_i = 1'b1; op_i = 3'd0; a_i = 23'd5; b_i = 23'd7; w_i = 23'd9;
    repeat (8) begin
      @(negedge clk);
      check(!vld_o && a_o == 0 && b_o == 0, "R8 reset outputs", {vld_o, a_o}, 0);
    end
    vld_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (LAT_NEG + 2) begin
      @(negedge clk);
      check(!vld_o, "R8 input during reset ignored", vld_o, 0);
    end
  endtask

  task automatic t_forward();
    fill_random();  run_batch(0, 64, 0, "fwd random");
    fill_edges();   run_batch(0, 64, 0, "fwd edges R10");
  endtask

  task automatic t_inverse();
    fill_random();  run_batch(1, 64, 0, "inv random");
    fill_edges();   run_batch(1, 64, 0, "inv edges R10");
  endtask

  task automatic t_pw_mul();
    fill_random();  run_batch(2, 64, 0, "mul random");
    fill_edges();   run_batch(2, 64, 0, "mul edges R10");
  endtask

  task automatic t_pw_add();
    fill_random();  run_batch(3, 64, 0, "add random");
    fill_edges();   run_batch(3, 64, 0, "add edges R10");
  endtask

  task automatic t_pw_sub();
    fill_random();  run_batch(4, 64, 0, "sub random");
    fill_edges();   run_batch(4, 64, 0, "sub edges R10");
  endtask

  task automatic t_bubbles();
    fill_random();  run_batch(0, 24, 2, "fwd gaps");
    fill_random();  run_batch(1, 24, 1, "inv gaps");
  endtask

  task automatic t_spare_codes();
    fill_random();  run_batch(5, 16, 0, "code5");
    fill_random();  run_batch(7, 16, 0, "code7");
  endtask

  task automatic t_directed();
    // forward wrap: a=q-1, b=1, w=1 gives A=0, B=q-2
    ta[0] = int'(QL - 1); tb_v[0] = 1; tw[0] = 1;
    // inverse odd sum halving: a=2, b=1 gives A=(q+3)/2
    ta[1] = 2; tb_v[1] = 1; tw[1] = 3;
    run_batch(0, 1, 0, "fwd wrap");
    ta[0] = ta[1]; tb_v[0] = tb_v[1]; tw[0] = tw[1];
    run_batch(1, 1, 0, "inv odd half");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_directed();
    t_forward();
    t_inverse();
    t_pw_mul();
    t_pw_add();
    t_pw_sub();
    t_bubbles();
    t_spare_codes();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule